// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable model of a small synchronous static memory with a registered read path and a four-beat burst counter. A cycle starts when one of two active-low address strobes is seen at a rising clock edge. One strobe is meant for a processor and one for a memory controller. The start address is captured, and its two lowest bits seed the burst counter. Later cycles without a strobe continue the burst. They either step the counter in linear order, wrapping within the aligned group of four words, or stay on the current word. A read returns its word one clock after the address is taken.

The data bus is split into an input vector, an output vector and an output-enable flag. Byte lanes of nine bits, eight data bits and one parity bit, are written under a global write enable together with a per-lane enable. An asynchronous sleep input freezes all activity and keeps the stored contents. A controller strobe taken while the chip enable is inactive deselects the device until the next accepted strobe.

Top module: `bsram_core`

## Requirements
- R1: After reset the device is deselected. `dq_oe` stays low, and cycles without a strobe start no access.
- R2: A processor strobe with `ce_n` low, or an accepted controller strobe with `ce_n` low, accesses `addr_i`. The counter loads `addr_i[1:0]`. For a read, the word at that address is on `dq_out` with `dq_oe` high (if `oe_n` is low) after the next rising edge.
- R3: When both strobes are low and `ce_n` is low, the processor strobe wins. That cycle is always a read, whatever the write enables are.
- R4: With `ce_n` high, the processor strobe is ignored. If the controller strobe is not asserted, the cycle behaves as a cycle without a strobe.
- R5: A controller strobe that is accepted while `ce_n` is high deselects the device. The following output is high impedance (`dq_oe` low), and later cycles without a strobe neither read nor write until a new strobe is accepted.
- R6: While the device is selected, a cycle without a strobe accesses {upper captured address bits, counter}. With `adv_n` low, the counter first steps by one modulo 4 (0,1,2,3,0). With `adv_n` high, it repeats the current word.
- R7: A selected cycle that is not a processor-strobe cycle, with `we_n` low, writes lane k (`dq_in[9k+8:9k]`) at the access address wherever `bwe_n[k]` is low. Other lanes keep their contents. A write cycle produces no read output on the following clock.
- R8: `oe_n` high forces `dq_oe` low at once, without touching the pipelined read state.
- R9: While `sleep_i` is high, no write, address capture or counter step takes place, `dq_oe` is low, and the stored data is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| ce_n | input | 1 | Primary chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Global write enable, active low |
| bwe_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| dq_in | input | LANES*9 | Write data, nine bits per lane |
| dq_out | output | LANES*9 | Registered read data |
| dq_oe | output | 1 | High when `dq_out` is driven |

## Verification
The assertions assume that every control input is stable and known at each rising edge. They also assume that `sleep_i` changes only between edges, even though the design treats it as asynchronous. The bench changes all inputs on the falling edge, and that includes sleep, so the edge sampling is never ambiguous. Before any read is compared, every word is written once, so the memory never returns unknown data. The random phase covers all combinations of strobes, enables, advance, sleep and output enable.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned CNT_W  = 2;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_CPU   = 3'd1,
    CYC_CTL   = 3'd2,
    CYC_BURST = 3'd3,
    CYC_DESEL = 3'd4
  } cyc_e;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              ce_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_en,
  output logic              acc_wr,
  output cyc_e              cyc
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  base_hi_q, base_hi_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_step;
  logic             sel_q, sel_d;
  logic             cpu_hit, ctl_hit, upd_en;

  always_comb begin
    cpu_hit  = !strb_cpu_n && !ce_n;
    ctl_hit  = !strb_ctl_n && !cpu_hit;
    cnt_step = adv_n ? cnt_q : cnt_q + CNT_W'(1);
    if (cpu_hit)             cyc = CYC_CPU;
    else if (ctl_hit && !ce_n) cyc = CYC_CTL;
    else if (ctl_hit)        cyc = CYC_DESEL;
    else if (sel_q)          cyc = CYC_BURST;
    else                     cyc = CYC_IDLE;
  end

  always_comb begin
    base_hi_d = base_hi_q;
    cnt_d     = cnt_q;
    sel_d     = sel_q;
    acc_addr  = {base_hi_q, cnt_step};
    unique case (cyc)
      CYC_CPU, CYC_CTL: begin
        base_hi_d = addr_i[ADDR_W-1:CNT_W];
        cnt_d     = addr_i[CNT_W-1:0];
        sel_d     = 1'b1;
        acc_addr  = addr_i;
      end
      CYC_BURST: cnt_d = cnt_step;
      CYC_DESEL: sel_d = 1'b0;
      default: ;
    endcase
    acc_en = !sleep_i && (cyc == CYC_CPU || cyc == CYC_CTL || cyc == CYC_BURST);
    acc_wr = acc_en && !we_n && (cyc != CYC_CPU);
    upd_en = !sleep_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi_q <= '0;
      cnt_q     <= '0;
      sel_q     <= 1'b0;
    end else if (upd_en) begin
      base_hi_q <= base_hi_d;
      cnt_q     <= cnt_d;
      sel_q     <= sel_d;
    end
  end

  assert_strobe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !ce_n && !strb_cpu_n) |=> (sel_q && cnt_q == $past(addr_i[CNT_W-1:0])));

  assert_cpu_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && ce_n && !strb_cpu_n && strb_ctl_n && adv_n) |=>
      ($stable(cnt_q) && $stable(base_hi_q) && $stable(sel_q)));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && ce_n && !strb_ctl_n) |=> !sel_q);

  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && strb_cpu_n && strb_ctl_n && sel_q && !adv_n) |=>
      (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(cnt_q) && $stable(sel_q) && $stable(base_hi_q)));
endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frz,
  input  logic                    en,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bwe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    rd_valid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic rd_valid_q, rd_valid_d, rd_take;

  always_comb begin
    rd_take    = en && !wr;
    rd_valid_d = rd_take;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic              lane_we;

    always_comb lane_we = en && wr && !bwe_n[k];

    always_ff @(posedge clk) begin
      if (lane_we) mem[addr] <= din[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_take) rd_q <= mem[addr];
    end

    assign dout[k*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_valid_q <= 1'b0;
    else if (!frz) rd_valid_q <= rd_valid_d;
  end

  assign rd_valid = rd_valid_q;

  assert_write_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr) |=> !rd_valid_q);
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  logic                    ce_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bwe_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_en, acc_wr, rd_valid;
  cyc_e              cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .sleep_i(sleep_i), .ce_n(ce_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .we_n(we_n), .addr_i(addr_i), .acc_addr(acc_addr), .acc_en(acc_en),
    .acc_wr(acc_wr), .cyc(cyc)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_int_n), .frz(sleep_i), .en(acc_en), .wr(acc_wr),
    .addr(acc_addr), .bwe_n(bwe_n), .din(dq_in), .dout(dq_out),
    .rd_valid(rd_valid)
  );

  always_comb dq_oe = rd_valid && !oe_n && !sleep_i;

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    oe_n |-> !dq_oe);

  assert_cpu_priority_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sleep_i && !ce_n && !strb_cpu_n && !strb_ctl_n && !we_n) |=> rd_valid);

  assert_cpu_cycle_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sleep_i && !ce_n && !strb_cpu_n) |-> (cyc == CYC_CPU && !acc_wr));

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    sleep_i |-> (!dq_oe && !acc_en));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !rd_valid);
endmodule

// File: tb/sim_bsram_core.sv
`timescale 1ns/1ps
module sim_bsram_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slp, ce_n, cpu_n, ctl_n, adv_n, we_n, oe_n;
  logic [1:0]  bwe_n;
  logic [7:0]  a;
  logic [17:0] d;
  logic [17:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  logic [17:0] mm [256];
  logic [7:0]  m_base;
  int          m_cnt;
  logic        m_sel, m_valid;
  logic [17:0] m_data;

  always #2.5 clk = ~clk;

  bsram_core u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(slp), .ce_n(ce_n),
    .strb_cpu_n(cpu_n), .strb_ctl_n(ctl_n), .adv_n(adv_n), .we_n(we_n),
    .bwe_n(bwe_n), .oe_n(oe_n), .addr_i(a), .dq_in(d),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic compare();
    logic exp_oe;
    exp_oe = m_valid && !oe_n && !slp;
    checks++;
    if (dq_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: dq_oe actual=%b expected=%b", tag, dq_oe, exp_oe);
    end
    if (exp_oe) begin
      checks++;
      if (dq_out !== m_data) begin
        errors++;
        $display("FAIL %s: dq_out actual=%h expected=%h", tag, dq_out, m_data);
      end
    end
  endtask

  task automatic model_edge();
    logic cpu, ctl, act, wr;
    logic [7:0] acc;
    if (slp) return;
    cpu = !cpu_n && !ce_n;
    ctl = !ctl_n && !cpu;
    act = 1'b0;
    acc = '0;
    if (cpu || (ctl && !ce_n)) begin
      acc = a; m_sel = 1'b1; m_base = a; m_cnt = int'(a[1:0]); act = 1'b1;
    end else if (ctl) begin
      m_sel = 1'b0;
    end else if (m_sel) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      acc = {m_base[7:2], 2'(m_cnt)};
      act = 1'b1;
    end
    wr = act && !cpu && !we_n;
    if (wr) begin
      if (!bwe_n[0]) mm[acc][8:0]  = d[8:0];
      if (!bwe_n[1]) mm[acc][17:9] = d[17:9];
    end
    m_valid = act && !wr;
    if (m_valid) m_data = mm[acc];
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_in();
    slp = 0; ce_n = 0; cpu_n = 1; ctl_n = 1; adv_n = 1; we_n = 1;
    oe_n = 0; bwe_n = 2'b11; a = '0; d = '0;
  endtask

  task automatic ctl_write(input logic [7:0] ad, input logic [17:0] dd, input logic [1:0] be);
    idle_in(); ctl_n = 0; we_n = 0; bwe_n = be; a = ad; d = dd;
    tick();
  endtask

  task automatic cpu_read(input logic [7:0] ad);
    idle_in(); cpu_n = 0; a = ad;
    tick();
  endtask

  task automatic burst(input logic adv);
    idle_in(); adv_n = adv;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_sel = 0; m_valid = 0; m_cnt = 0; m_base = '0; m_data = '0;
    idle_in(); ce_n = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    repeat (3) begin ce_n = 1; tick(); end
    burst(1'b0);
    burst(1'b0);

    tag = "R7";
    for (int i = 0; i < 256; i++) ctl_write(8'(i), 18'((i * 1031 + 7) & 18'h3FFFF), 2'b00);

    tag = "R2";
    cpu_read(8'h10); cpu_read(8'hA7); cpu_read(8'hFF); burst(1'b1); burst(1'b1);

    tag = "R6";
    cpu_read(8'h42);
    repeat (5) burst(1'b0);
    burst(1'b1); burst(1'b0);

    tag = "R7";
    ctl_write(8'h33, 18'h2AAAA, 2'b10);
    ctl_write(8'h34, 18'h15555, 2'b01);
    cpu_read(8'h33); cpu_read(8'h34); burst(1'b1);

    tag = "R3";
    idle_in(); cpu_n = 0; ctl_n = 0; we_n = 0; bwe_n = 2'b00; a = 8'h80; d = 18'h3FFFF; tick();
    cpu_read(8'h80); burst(1'b1);

    tag = "R4";
    cpu_read(8'h21);
    idle_in(); ce_n = 1; cpu_n = 0; adv_n = 0; a = 8'hC4; tick();
    idle_in(); ce_n = 1; cpu_n = 0; adv_n = 1; a = 8'hC8; tick();
    burst(1'b1);

    tag = "R5";
    cpu_read(8'h50);
    idle_in(); ce_n = 1; ctl_n = 0; a = 8'h60; tick();
    idle_in(); we_n = 0; bwe_n = 2'b00; d = 18'h00001; adv_n = 0; tick();
    burst(1'b0); burst(1'b1);
    cpu_read(8'h50); cpu_read(8'h51); burst(1'b1);

    tag = "R8";
    cpu_read(8'h90);
    idle_in(); oe_n = 1; adv_n = 0; tick();
    burst(1'b0);
    idle_in(); oe_n = 1; tick();

    tag = "R9";
    cpu_read(8'hB0);
    idle_in(); slp = 1; ctl_n = 0; we_n = 0; bwe_n = 2'b00; a = 8'hB1; d = 18'h12345; tick();
    idle_in(); slp = 1; adv_n = 0; tick();
    burst(1'b1);
    cpu_read(8'hB1); burst(1'b1);

    tag = "mixed";
    for (int i = 0; i < 400; i++) begin
      slp   = ($urandom_range(0, 9) == 0);
      ce_n  = ($urandom_range(0, 4) == 0);
      cpu_n = ($urandom_range(0, 2) != 0);
      ctl_n = ($urandom_range(0, 2) != 0);
      adv_n = 1'($urandom_range(0, 1));
      we_n  = 1'($urandom_range(0, 1));
      bwe_n = 2'($urandom_range(0, 3));
      oe_n  = ($urandom_range(0, 5) == 0);
      a     = 8'($urandom_range(0, 255));
      d     = 18'($urandom_range(0, 262143));
      tick();
    end
    idle_in(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule